// File: doc/BRIEF.md
# Serial Write-Only Tuning Register Port

This block is a three-wire serial slave. It sets a small bank of tuning registers: gain trim, offset trim, a coarse and a fine sampling-delay step, and a state word. A host drives a serial clock, an active-low frame strobe and a data line. Each frame carries a register address followed by a data byte. Nothing can be read back through this port.

All three serial pins are brought into the system clock domain through synchronizer chains. Every decision is then taken on edges detected in that domain: shifting a bit, starting a frame and closing a frame. The register outputs are therefore plain system-clock flops, and downstream logic can use them without any further crossing. A frame only takes effect when it closes, and only when it has exactly the expected length and names a known address. Anything else leaves the bank as it was. An active-low reset puts every register back to its default value.

Top module: `tws_regport`

## Requirements
- R1: While rstN is low, and after it is released, the outputs hold their defaults: gainAdj=0x80, offsetAdj=0x80, delayCoarse=0x00, delayFine=0x00, stateReg=0x00.
- R2: A bit is taken on each rising edge of sClk while sLoadN is low. Bits arrive most significant first. The first 4 bits form the address and the next 8 bits form the data byte.
- R3: Rising edges of sClk while sLoadN is high are not counted and do not alter any register.
- R4: A register changes only after the rising edge of sLoadN that closes the frame. The new value is visible within 4 rising edges of sysClk after that edge. Before the strobe rises, the outputs keep their old values.
- R5: A frame is applied only if exactly 12 bits were taken between the falling and the rising edge of sLoadN. Frames of 11 or 13 bits leave every register unchanged.
- R6: Address 0001 selects gainAdj, 0100 selects offsetAdj, 0010 selects delayCoarse, 0011 selects delayFine and 0110 selects stateReg. A frame with any other address changes nothing.
- R7: A valid frame changes only the register it addresses. Writing the same register again replaces its value.
- R8: Asserting rstN in the middle of a frame restores the defaults and discards that frame, even if the remaining bits are clocked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock; all state and outputs are in this domain |
| rstN | input | 1 | Asynchronous active-low reset to defaults |
| sClk | input | 1 | Serial clock from the host |
| sLoadN | input | 1 | Active-low frame strobe |
| sData | input | 1 | Serial data, MSB first |
| gainAdj | output | 8 | Gain trim value |
| offsetAdj | output | 8 | Offset trim value |
| delayCoarse | output | 8 | Coarse sampling-delay step |
| delayFine | output | 8 | Fine sampling-delay step |
| stateReg | output | 8 | State word |

## Verification
The bench sends frames of 11 and 13 bits. In the 13-bit frame, the last 12 bits happen to form a valid gain write. A design that counted wrongly, or that kept only the trailing 12 bits, would therefore load 0x55 into the gain register. It uses an asymmetric data byte to expose bit reversal, unmapped addresses at both ends of the code space, and clock pulses while the strobe is high that a careless shifter would count. It checks the outputs just before the strobe rises, to catch an early update. It also resets the block in the middle of a frame and then finishes that frame: a design that kept the partial shift state across reset would apply it.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 5;
  localparam int SYNC_STAGES = 2;

  // register slots: 0 gain, 1 offset, 2 coarse delay, 3 fine delay, 4 state
  localparam logic [NUM_REGS-1:0][ADDR_W-1:0] REG_ADDR =
    {4'b0110, 4'b0011, 4'b0010, 4'b0100, 4'b0001};
  localparam logic [NUM_REGS-1:0][DATA_W-1:0] REG_DEFAULT =
    {8'h00, 8'h00, 8'h00, 8'h80, 8'h80};

  typedef struct packed {
    logic clearCnt;
    logic shiftBit;
    logic commit;
  } twsStrobe_t;
endpackage

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sClk,
  input  logic       sLoadN,
  input  logic       sData,
  output twsStrobe_t strobes,
  output logic       bitIn,
  output logic       loadIdle
);
  logic [STAGES-1:0] clkSync;
  logic [STAGES-1:0] loadSync;
  logic [STAGES-1:0] dataSync;
  logic clkPrev;
  logic loadPrev;
  logic clkLvl;
  logic loadLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      loadSync <= '1;
      dataSync <= '0;
      clkPrev  <= 1'b0;
      loadPrev <= 1'b1;
    end else begin
      clkSync  <= {clkSync[STAGES-2:0], sClk};
      loadSync <= {loadSync[STAGES-2:0], sLoadN};
      dataSync <= {dataSync[STAGES-2:0], sData};
      clkPrev  <= clkSync[STAGES-1];
      loadPrev <= loadSync[STAGES-1];
    end
  end

  assign clkLvl  = clkSync[STAGES-1];
  assign loadLvl = loadSync[STAGES-1];

  always_comb begin
    strobes.clearCnt = loadPrev & ~loadLvl;
    strobes.shiftBit = clkLvl & ~clkPrev & ~loadLvl;
    strobes.commit   = loadLvl & ~loadPrev;
  end

  assign bitIn    = dataSync[STAGES-1];
  assign loadIdle = loadLvl;
endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NR = NUM_REGS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  twsStrobe_t             strobes,
  input  logic                   bitIn,
  output logic [NR-1:0][DW-1:0]  regsOut,
  output logic [$clog2(AW+DW+2)-1:0] bitCnt,
  output logic                   frameOk
);
  localparam int FRAME_LEN = AW + DW;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_LEN + 1);

  logic [FRAME_LEN-1:0] shiftQ;
  logic [AW-1:0]        frameAddr;
  logic [DW-1:0]        frameData;
  logic [NR-1:0]        hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shiftQ <= '0;
    end else if (strobes.clearCnt) begin
      bitCnt <= '0;
    end else if (strobes.shiftBit) begin
      shiftQ <= {shiftQ[FRAME_LEN-2:0], bitIn};
      if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign frameAddr = shiftQ[FRAME_LEN-1:DW];
  assign frameData = shiftQ[DW-1:0];
  assign frameOk   = strobes.commit && (bitCnt == CNT_FULL) && (|hit);

  for (genvar i = 0; i < NR; i++) begin : g_reg
    assign hit[i] = (frameAddr == REG_ADDR[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 regsOut[i] <= REG_DEFAULT[i];
      else if (frameOk && hit[i]) regsOut[i] <= frameData;
    end
  end
endmodule

// File: rtl/tws_regport.sv
module tws_regport
  import tws_pkg::*;
(
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             sClk,
  input  logic             sLoadN,
  input  logic             sData,
  output logic [DATA_W-1:0] gainAdj,
  output logic [DATA_W-1:0] offsetAdj,
  output logic [DATA_W-1:0] delayCoarse,
  output logic [DATA_W-1:0] delayFine,
  output logic [DATA_W-1:0] stateReg
);
  localparam int CNT_W = $clog2(ADDR_W + DATA_W + 2);

  twsStrobe_t                        strobes;
  logic                              bitIn;
  logic                              loadIdle;
  logic [NUM_REGS-1:0][DATA_W-1:0]   regsOut;
  logic [CNT_W-1:0]                  bitCnt;
  logic                              frameOk;

  tws_ctrl u_ctrl (
    .clk(sysClk), .rstN(rstN), .sClk(sClk), .sLoadN(sLoadN), .sData(sData),
    .strobes(strobes), .bitIn(bitIn), .loadIdle(loadIdle)
  );

  tws_datapath u_dp (
    .clk(sysClk), .rstN(rstN), .strobes(strobes), .bitIn(bitIn),
    .regsOut(regsOut), .bitCnt(bitCnt), .frameOk(frameOk)
  );

  assign gainAdj     = regsOut[0];
  assign offsetAdj   = regsOut[1];
  assign delayCoarse = regsOut[2];
  assign delayFine   = regsOut[3];
  assign stateReg    = regsOut[4];
endmodule

// File: rtl/tws_regport_chk.sv
module tws_regport_chk
  import tws_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             commit,
  input logic             clearCnt,
  input logic             loadIdle,
  input logic [$clog2(ADDR_W+DATA_W+2)-1:0] bitCnt,
  input logic [DATA_W-1:0] gain,
  input logic [DATA_W-1:0] offset,
  input logic [DATA_W-1:0] coarse,
  input logic [DATA_W-1:0] fine,
  input logic [DATA_W-1:0] stat
);
  localparam int FRAME_LEN = ADDR_W + DATA_W;
  logic [5*DATA_W-1:0] allRegs;
  assign allRegs = {gain, offset, coarse, fine, stat};

  // R1
  reset_default_chk: assert property (@(posedge clk)
    !rstN |=> (gain == 8'h80 && offset == 8'h80 && coarse == 8'h00 && fine == 8'h00 && stat == 8'h00));

  // R4
  no_commit_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(allRegs));

  // R5
  bad_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commit && bitCnt != FRAME_LEN) |=> $stable(allRegs));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FRAME_LEN + 1);

  // R3
  idle_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadIdle && !clearCnt) |=> $stable(bitCnt));

  // R7
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> ($countones({gain != $past(gain), offset != $past(offset),
                            coarse != $past(coarse), fine != $past(fine),
                            stat != $past(stat)}) <= 1));
endmodule

bind tws_regport tws_regport_chk u_chk (
  .clk(sysClk), .rstN(rstN), .commit(strobes.commit), .clearCnt(strobes.clearCnt),
  .loadIdle(loadIdle), .bitCnt(bitCnt), .gain(gainAdj), .offset(offsetAdj),
  .coarse(delayCoarse), .fine(delayFine), .stat(stateReg)
);

// File: tb/tws_regport_bench.sv
module tws_regport_bench;
  logic sysClk = 1'b0;
  logic rstN = 1'b0;
  logic sClk = 1'b0;
  logic sLoadN = 1'b1;
  logic sData = 1'b0;
  logic [7:0] gainAdj, offsetAdj, delayCoarse, delayFine, stateReg;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [5];
  logic [39:0] expQ [$];
  string tagQ [$];

  always #5 sysClk = ~sysClk;

  tws_regport u_tws_regport (
    .sysClk(sysClk), .rstN(rstN), .sClk(sClk), .sLoadN(sLoadN), .sData(sData),
    .gainAdj(gainAdj), .offsetAdj(offsetAdj), .delayCoarse(delayCoarse),
    .delayFine(delayFine), .stateReg(stateReg)
  );

  task automatic checkVal(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag, logic [39:0] e);
    checkVal(tag, "gainAdj",     gainAdj,     e[39:32]);
    checkVal(tag, "offsetAdj",   offsetAdj,   e[31:24]);
    checkVal(tag, "delayCoarse", delayCoarse, e[23:16]);
    checkVal(tag, "delayFine",   delayFine,   e[15:8]);
    checkVal(tag, "stateReg",    stateReg,    e[7:0]);
  endtask

  function automatic logic [39:0] packModel();
    return {model[0], model[1], model[2], model[3], model[4]};
  endfunction

  function automatic int slotOf(logic [3:0] a);
    case (a)
      4'b0001: return 0;
      4'b0100: return 1;
      4'b0010: return 2;
      4'b0011: return 3;
      4'b0110: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic modelReset();
    model[0] = 8'h80; model[1] = 8'h80; model[2] = 8'h00; model[3] = 8'h00; model[4] = 8'h00;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic pushExpect(string tag);
    expQ.push_back(packModel());
    tagQ.push_back(tag);
    wait (expQ.size() == 0);
  endtask

  // sends nbits taken MSB first from word[nbits-1:0]; resetAt >= 0 pulses reset before that bit
  task automatic sendFrame(logic [15:0] word, int nbits, int resetAt, string tag);
    bit aborted = 0;
    sLoadN = 1'b0;
    waitCycles(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      if (nbits - 1 - i == resetAt) begin
        rstN = 1'b0;
        modelReset();
        aborted = 1;
        waitCycles(3);
        rstN = 1'b1;
        waitCycles(4);
      end
      sData = word[i];
      waitCycles(4);
      sClk = 1'b1;
      waitCycles(4);
      sClk = 1'b0;
    end
    waitCycles(8);
    // R4: nothing applied before the strobe rises
    compareAll("R4", packModel());
    sLoadN = 1'b1;
    if (nbits == 12 && !aborted && slotOf(word[11:8]) >= 0)
      model[slotOf(word[11:8])] = word[7:0];
    pushExpect(tag);
  endtask

  // monitor: R4 latency, value within a few sysClk cycles of strobe rise
  initial begin
    forever begin
      wait (expQ.size() != 0);
      waitCycles(5);
      compareAll(tagQ[0], expQ[0]);
      void'(tagQ.pop_front());
      void'(expQ.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge sysClk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    modelReset();
    waitCycles(4);
    // R1 defaults during reset
    compareAll("R1", packModel());
    rstN = 1'b1;
    waitCycles(4);
    pushExpect("R1");

    // R2 R6 each mapped address, asymmetric data exposes bit order
    sendFrame(16'h011E, 12, -1, "R2");
    sendFrame(16'h04C3, 12, -1, "R6");
    sendFrame(16'h0207, 12, -1, "R6");
    sendFrame(16'h03A9, 12, -1, "R6");
    sendFrame(16'h0661, 12, -1, "R6");

    // R5 short and long frames; long one ends in a valid gain write
    sendFrame(16'h0123, 11, -1, "R5");
    sendFrame(16'h1155, 13, -1, "R5");

    // R6 unmapped addresses
    sendFrame(16'h00FF, 12, -1, "R6");
    sendFrame(16'h0FFF, 12, -1, "R6");

    // R3 clock pulses with strobe high
    sData = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sClk = 1'b1; waitCycles(4); sClk = 1'b0; waitCycles(4);
    end
    pushExpect("R3");
    sendFrame(16'h0242, 12, -1, "R3");

    // R7 rewrite same register, others untouched
    sendFrame(16'h01F0, 12, -1, "R7");

    // R8 reset in mid frame
    sendFrame(16'h0399, 12, 6, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule